// File: doc/BRIEF.md
# Edge-Capturing GPIO Controller

This block is a 32-pin general-purpose I/O controller. Software reaches it through a simple word-wide register bus. Each pin is set up as an input or as an output. Output pins drive the value held in the data register. Input pins are brought into the clock domain through two flops. The synchronized value is then copied into the data register and watched for edges.

A detected edge sets a sticky event bit. A per-pin control bit chooses what counts as an event: either edge, or only a high-to-low transition. The single interrupt line is a level. It stays high while any event bit is also enabled in the mask register. Software acknowledges events by writing ones to the event register. The bit order is reversed against the pins: pin n lives in register bit 31−n. An open-drain configuration register is kept for software, but it does not change the pad drive.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: While reset is low and after it is released, every register reads 0 and `irq`, `pin_oe` and `pin_out` are 0.
- R2: Full-word writes update the registers at these offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, control 0x14. A full-word read returns the register on `bus_rdata` in the cycle after `bus_re`. Direction, open-drain, mask and control read back exactly what was written.
- R3: Pin n of `pin_in`, `pin_out` and `pin_oe` corresponds to register bit 31−n, so pin 0 is bit 31.
- R4: A direction bit of 1 makes the pin an output. `pin_oe` mirrors the direction register. `pin_out` carries the data bit for output pins and 0 for input pins. A write to the data register changes only the bits whose direction is output.
- R5: For an input pin (direction 0), the data bit follows the pin three clock edges after the pin changes. An output pin's input level changes neither its data bit nor its event bit.
- R6: With control bit 0, both a rising and a falling edge on an input pin set its event bit.
- R7: With control bit 1, only a high-to-low transition sets the event bit. A rising edge leaves it clear.
- R8: Writing to the event offset clears every event bit written as 1 and leaves bits written as 0 unchanged.
- R9: `irq` is 1 exactly when (event AND mask) is non-zero. It reflects a register write in the cycle after that write.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. Any access whose `bus_size` is not 2 (2 = 32-bit word; 0 = byte, 1 = half-word) is ignored, and a read of that kind returns 0.
- R11: When an edge sets an event bit in the same cycle that software clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code, 2 = full word |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Asynchronous pin levels, index = pin number |
| pin_out | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Pin output enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the case where an edge and a software clear land on the same event bit in the same cycle. A design that lets the clear win would silently drop that edge, and the event would read back as 0. It also checks the falling-only control: a wrong design would flag the rising edge or miss the falling one. It toggles a pin set as output, which would corrupt the data or raise an event if input sampling ignored direction. It also verifies the reversed bit order, where a straight mapping would show pin 0 in bit 0. Partial-width and unmapped accesses are checked to leave the direction register untouched.

// File: rtl/gpio_edge_pkg.sv
// Shared constants and types for the edge-capturing GPIO controller.
// Assumes a byte-addressed bus with word-aligned registers.
package gpio_edge_pkg;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam int OFS_DIR  = 'h00;
    localparam int OFS_ODR  = 'h04;
    localparam int OFS_DAT  = 'h08;
    localparam int OFS_EV   = 'h0C;
    localparam int OFS_MASK = 'h10;
    localparam int OFS_CTL  = 'h14;

    typedef enum logic [2:0] {
        SEL_DIR, SEL_ODR, SEL_DAT, SEL_EV, SEL_MASK, SEL_CTL, SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/gpio_edge_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_edge_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    // Two register stages to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
// Per-pin edge detector. Compares the synchronized level with the level
// seen one cycle earlier and qualifies the change by direction and mode.
// Assumes sync_in is already in the clock domain.
module gpio_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] fall_only,
    output logic [W-1:0] ev_set
);
    logic [W-1:0] prev_q;

    // Remember the last sampled level of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    // Event request per pin: input direction, a change, and a mode match.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic changed, falling;
        assign changed   = sync_in[i] ^ prev_q[i];
        assign falling   = prev_q[i] & ~sync_in[i];
        assign ev_set[i] = ~dir[i] & changed & (~fall_only[i] | falling);
    end
endmodule

// File: rtl/gpio_edge_regs.sv
// Register file: decode, write side effects, sticky events and read mux.
// Assumes at most one access per cycle; a read returns pre-write values.
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      sync_in,
    input  logic [W-1:0]      ev_set,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      dat_q,
    output logic [W-1:0]      ev_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      ctl_q
);
    reg_sel_e     sel;
    logic [W-1:0] odr_q;
    logic [W-1:0] rd_val;
    logic [W-1:0] clr_bits;
    logic         wr_dat;

    // Decode a full-word access to a register select.
    always_comb begin
        sel = SEL_NONE;
        if (bus_size == SIZE_WORD) begin
            case (bus_addr)
                ADDR_W'(OFS_DIR):  sel = SEL_DIR;
                ADDR_W'(OFS_ODR):  sel = SEL_ODR;
                ADDR_W'(OFS_DAT):  sel = SEL_DAT;
                ADDR_W'(OFS_EV):   sel = SEL_EV;
                ADDR_W'(OFS_MASK): sel = SEL_MASK;
                ADDR_W'(OFS_CTL):  sel = SEL_CTL;
                default:           sel = SEL_NONE;
            endcase
        end
    end

    assign wr_dat   = bus_we && (sel == SEL_DAT);
    assign clr_bits = (bus_we && (sel == SEL_EV)) ? bus_wdata : '0;

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            odr_q  <= '0;
            mask_q <= '0;
            ctl_q  <= '0;
        end else if (bus_we) begin
            if (sel == SEL_DIR)  dir_q  <= bus_wdata;
            if (sel == SEL_ODR)  odr_q  <= bus_wdata;
            if (sel == SEL_MASK) mask_q <= bus_wdata;
            if (sel == SEL_CTL)  ctl_q  <= bus_wdata;
        end
    end

    // Data: outputs take software writes, inputs track the synchronized pins.
    always_ff @(posedge clk) begin
        if (!rst_n) dat_q <= '0;
        else        dat_q <= (dir_q & (wr_dat ? bus_wdata : dat_q)) | (~dir_q & sync_in);
    end

    // Sticky events: write-one-to-clear, a same-cycle hardware set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~clr_bits) | ev_set;
    end

    // Read multiplexer; unmapped or partial accesses read as zero.
    always_comb begin
        case (sel)
            SEL_DIR:  rd_val = dir_q;
            SEL_ODR:  rd_val = odr_q;
            SEL_DAT:  rd_val = dat_q;
            SEL_EV:   rd_val = ev_q;
            SEL_MASK: rd_val = mask_q;
            SEL_CTL:  rd_val = ctl_q;
            default:  rd_val = '0;
        endcase
    end

    // Registered read data, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the edge-capturing GPIO controller. Reverses pin order into
// register bit order, synchronizes inputs, detects edges, holds the
// registers and forms the level interrupt.
// Assumes pin_in is asynchronous and pin_out/pin_oe feed a pad ring.
module gpio_edge_ctrl #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] in_bits;
    logic [NPINS-1:0] sync_bits;
    logic [NPINS-1:0] ev_set;
    logic [NPINS-1:0] dir_q, dat_q, ev_q, mask_q, ctl_q;

    // Pin n maps to register bit NPINS-1-n in both directions.
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        localparam int B = NPINS - 1 - n;
        assign in_bits[B] = pin_in[n];
        assign pin_oe[n]  = dir_q[B];
        assign pin_out[n] = dir_q[B] & dat_q[B];
    end

    gpio_edge_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (in_bits),
        .sync_out (sync_bits)
    );

    gpio_edge_detect #(.W(NPINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_bits),
        .dir       (dir_q),
        .fall_only (ctl_q),
        .ev_set    (ev_set)
    );

    gpio_edge_regs #(.W(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_bits),
        .ev_set    (ev_set),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .ev_q      (ev_q),
        .mask_q    (mask_q),
        .ctl_q     (ctl_q)
    );

    // Interrupt level: any enabled pending event.
    assign irq = |(ev_q & mask_q);
endmodule

// File: rtl/gpio_edge_chk.sv
// Assertion checker for gpio_edge_ctrl, attached by bind below.
// Assumes it observes the top's ports and its internal register state.
module gpio_edge_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_we,
    input logic              bus_re,
    input logic [NPINS-1:0]  bus_rdata,
    input logic              irq,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  ev_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  ev_set
);
    logic word, mapped, hit_dir, hit_ev, hit_mask;

    assign word     = (bus_size == SIZE_WORD);
    assign hit_dir  = word && (bus_addr == ADDR_W'(OFS_DIR));
    assign hit_ev   = word && (bus_addr == ADDR_W'(OFS_EV));
    assign hit_mask = word && (bus_addr == ADDR_W'(OFS_MASK));
    assign mapped   = word && ((bus_addr == ADDR_W'(OFS_DIR)) || (bus_addr == ADDR_W'(OFS_ODR)) ||
                               (bus_addr == ADDR_W'(OFS_DAT)) || hit_ev || hit_mask ||
                               (bus_addr == ADDR_W'(OFS_CTL)));

    // R1: reset drives every visible output and state to zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == '0 && !irq && pin_oe == '0 && ev_q == '0 && dir_q == '0));

    // R2: a direction read returns the register value of the read cycle.
    a_r2_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_re && hit_dir) |-> bus_rdata == $past(dir_q));

    // R5: an output-direction pin never gains a new event.
    a_r5_no_output_event: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ev_q & ~$past(ev_q) & $past(dir_q)) == '0));

    // R8: event bits only fall after a write to the event offset.
    a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (($past(ev_q) & ~ev_q) != '0) |-> $past(bus_we && hit_ev));

    // R9: the interrupt rises only after a mask write or a new event.
    a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(irq) |-> $past((bus_we && hit_mask) || (ev_set != '0)));

    // R9: the interrupt falls only after a mask or event write.
    a_r9_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(irq) |-> $past(bus_we && (hit_mask || hit_ev)));

    // R10: unmapped or partial reads return zero.
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_re && !mapped) |-> bus_rdata == '0);

    // R11: every requested event bit is set in the following cycle.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(ev_set) != '0) |-> ((ev_q & $past(ev_set)) == $past(ev_set)));
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .ev_q      (ev_q),
    .dir_q     (dir_q),
    .ev_set    (ev_set)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    gpio_edge_ctrl #(.NPINS(32), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Each entry: {offset, write value, expected read-back}.
    localparam logic [71:0] VECS [0:5] = '{
        {8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        {8'h04, 32'h1234_5678, 32'h1234_5678},
        {8'h10, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
        {8'h14, 32'hCAFE_0001, 32'hCAFE_0001},
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h40, 32'hDEAD_BEEF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_size = 2'd2;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        bus_addr = a; bus_size = sz; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0; bus_size = 2'd2;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 pin_oe in reset", pin_oe, 32'h0);
        chk("R1 pin_out in reset", pin_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            rdreg(8'(i * 4), rd);
            chk("R1 register zero after reset", rd, 32'h0);
        end

        // Table walk: R2 read-back and R10 unmapped offsets.
        for (int i = 0; i < 6; i++) begin
            wr(VECS[i][71:64], VECS[i][63:32]);
            rdreg(VECS[i][71:64], rd);
            chk((VECS[i][31:0] == 0) ? "R10 unmapped offset" : "R2 register read-back", rd, VECS[i][31:0]);
        end
        wr(8'h00, 0); wr(8'h04, 0); wr(8'h10, 0); wr(8'h14, 0);

        // R3/R4: outputs on register bits 7..0 appear on pins 24..31.
        wr(8'h00, 32'h0000_00FF);
        wr(8'h08, 32'hFFFF_FFFF);
        chk("R3 pin_oe order", pin_oe, 32'hFF00_0000);
        chk("R4 pin_out value", pin_out, 32'hFF00_0000);
        rdreg(8'h08, rd);
        chk("R4 data write only on outputs", rd, 32'h0000_00FF);
        wr(8'h00, 32'h0000_000F);
        chk("R4 pin_out masked by direction", pin_out, 32'hF000_0000);

        // R5/R6: pin 0 rises, maps to bit 31, any-edge event.
        pin_in[0] = 1'b1;
        settle();
        rdreg(8'h08, rd);
        chk("R5 input tracked in data", rd, 32'h8000_000F);
        rdreg(8'h0C, rd);
        chk("R6 rising edge event", rd, 32'h8000_0000);
        chk("R9 irq low while masked", {31'b0, irq}, 32'h0);

        // R5: toggling an output pin changes nothing.
        pin_in[31] = 1'b1; settle();
        pin_in[31] = 1'b0; settle();
        rdreg(8'h08, rd);
        chk("R5 output pin ignores input data", rd, 32'h8000_000F);
        rdreg(8'h0C, rd);
        chk("R5 output pin raises no event", rd, 32'h8000_0000);

        // R9/R8: mask enables irq, write-one-to-clear semantics.
        wr(8'h10, 32'h8000_0000);
        chk("R9 irq after mask write", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h7FFF_FFFF);
        rdreg(8'h0C, rd);
        chk("R8 zeros leave event", rd, 32'h8000_0000);
        chk("R8 irq still high", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h8000_0000);
        chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
        rdreg(8'h0C, rd);
        chk("R8 ones clear event", rd, 32'h0);

        // R6: falling edge also captured in any-edge mode.
        pin_in[0] = 1'b0;
        settle();
        rdreg(8'h0C, rd);
        chk("R6 falling edge event", rd, 32'h8000_0000);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R7: falling-only mode on pin 1 (bit 30).
        wr(8'h14, 32'h4000_0000);
        wr(8'h10, 32'hC000_0000);
        pin_in[1] = 1'b1;
        settle();
        rdreg(8'h0C, rd);
        chk("R7 rising edge ignored", rd, 32'h0);
        chk("R7 irq stays low", {31'b0, irq}, 32'h0);
        pin_in[1] = 1'b0;
        settle();
        rdreg(8'h0C, rd);
        chk("R7 falling edge captured", rd, 32'h4000_0000);
        chk("R9 irq from falling event", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R11: edge on pin 2 lands in the same cycle as its clear.
        pin_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(8'h0C, 32'h2000_0000);
        rdreg(8'h0C, rd);
        chk("R11 set wins over clear", rd, 32'h2000_0000);
        wr(8'h0C, 32'h2000_0000);
        rdreg(8'h0C, rd);
        chk("R8 later clear succeeds", rd, 32'h0);

        // R10: partial-width and unmapped accesses are ignored.
        wr(8'h00, 32'hFFFF_FFFF, 2'd1);
        rdreg(8'h00, rd);
        chk("R10 half-word write ignored", rd, 32'h0000_000F);
        rdreg(8'h00, rd, 2'd0);
        chk("R10 byte read returns zero", rd, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rdreg(8'h00, rd);
        chk("R10 unmapped write ignored", rd, 32'h0000_000F);

        // R1: mid-run reset clears everything.
        pin_in = '0;
        wr(8'h10, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 pin_oe after reset", pin_oe, 32'h0);
        chk("R1 pin_out after reset", pin_out, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rdreg(8'h10, rd);
        chk("R1 mask cleared by reset", rd, 32'h0);
        rdreg(8'h00, rd);
        chk("R1 direction cleared by reset", rd, 32'h0);

        summary();
        $finish;
    end
endmodule